// File: doc/BRIEF.md
# Address-Keyed Line Timer Table

This block keeps a small associative set of timers, each bound to a cache-line address. A cache controller arms a timer for a line when it enters a guarded state that must end after a bounded time, cancels the timer if the line leaves that state early, and polls the table each cycle to learn whether some armed timer has run out. When one has, the table names the line, and the controller takes it with a pop command, which removes that timer.

Each entry stores the address and an absolute deadline: the value of a free-running cycle counter at the time of arming plus the requested relative timeout. Deadlines are compared against the counter with wrap-safe subtraction, so the counter may be narrow and wrap freely. Every timer runs on its own. Arming an address that already has a timer moves its deadline and never creates a second entry. When the table is full, an attempt to arm a new address is refused and flagged. When several timers are due together, the one with the earliest deadline is reported first.

Top module: `line_timer_table`

## Requirements
- R1: After reset no entry is held, the cycle counter is zero, and `ready_o` and `set_reject_o` are low.
- R2: A set for an address with no entry stores it in the lowest-numbered free slot with deadline = counter + `timeout_i`; with the set sampled on one rising edge, `ready_o` reports that address after max(`timeout_i`,1) rising edges counting that one, and not earlier.
- R3: A set for an address that already has an entry replaces that entry's deadline, uses no second slot, and is accepted even when the table is full.
- R4: An unset removes the entry holding `addr_i` from the next edge on; an unset for an address with no entry changes nothing.
- R5: A set for a new address while all slots are in use is refused, leaves the table unchanged, and raises `set_reject_o` for exactly the one cycle after that edge.
- R6: `ready_o` is high whenever at least one held entry has reached its deadline; `ready_addr_o` then gives the due entry with the earliest deadline, and among equal deadlines the one in the lowest-numbered slot.
- R7: Timers are independent: a due entry stays reported until it is popped, unset or re-armed, whatever happens to other entries.
- R8: A pop while `ready_o` is high removes exactly the entry shown on `ready_addr_o`; a pop while `ready_o` is low changes nothing.
- R9: One command acts per cycle, with set ahead of unset and unset ahead of pop; a lower-ranked command in the same cycle is ignored.
- R10: Deadlines stay correct when the counter wraps, for any `timeout_i` value from 0 to 2^(TIME_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Arm or re-arm a timer for `addr_i` |
| unset_i | input | 1 | Cancel the timer for `addr_i` |
| pop_i | input | 1 | Take the currently reported due timer |
| addr_i | input | ADDR_W | Line address for set and unset |
| timeout_i | input | TIME_W-1 | Relative timeout in cycles for set |
| ready_o | output | 1 | Some timer has reached its deadline |
| ready_addr_o | output | ADDR_W | Address of the reported due timer |
| set_reject_o | output | 1 | The set of the previous cycle was refused (table full) |

## Verification
`ready_o` and `ready_addr_o` are decoded from stored state only, so a set, unset or pop shows its effect on them one rising edge after it is sampled, and a new timer becomes due max(T,1) edges after its set edge; `set_reject_o` is registered and appears in the cycle after the refused set. The bench changes inputs on the falling edge and compares all outputs at the following falling edge against a reference table that is stepped once per rising edge with an unbounded integer clock, so deadlines never wrap in the reference. Directed sequences cover the zero and one timeouts, re-arming, full-table refusal, deadline ties and command priority, and a long randomized run crosses many counter wraps while popping due entries early enough to stay inside the wrap-safe window.

// File: rtl/ltt_pkg.sv
package ltt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_ARM    = 2'd1,
    OP_DISARM = 2'd2,
    OP_TAKE   = 2'd3
  } ltt_op_e;

  // Command ranking: arm beats disarm beats take.
  function automatic ltt_op_e rank_op(input logic arm, input logic disarm, input logic take);
    if (arm)    return OP_ARM;
    if (disarm) return OP_DISARM;
    if (take)   return OP_TAKE;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/ltt_slot.sv
module ltt_slot #(
  parameter int ADDR_W = 32,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TIME_W-1:0] deadline_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              due_o,
  output logic [TIME_W-1:0] age_o
);

  // Cycles elapsed since the deadline, modulo the counter range.
  function automatic logic [TIME_W-1:0] lag_of(input logic [TIME_W-1:0] now,
                                                input logic [TIME_W-1:0] dl);
    return now - dl;
  endfunction

  // Wrap-safe: the deadline has been reached when the lag is non-negative.
  function automatic logic reached(input logic [TIME_W-1:0] lag);
    return !lag[TIME_W-1];
  endfunction

  logic              valid_q;
  logic              fired_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TIME_W-1:0] dl_q;
  logic [TIME_W-1:0] lag_w;

  assign lag_w = lag_of(now_i, dl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fired_q <= 1'b0;
      addr_q  <= '0;
      dl_q    <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      fired_q <= 1'b0;
      addr_q  <= addr_i;
      dl_q    <= deadline_i;
    end else if (drop_i) begin
      valid_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (valid_q && reached(lag_w)) begin
      fired_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign due_o   = valid_q && (fired_q || reached(lag_w));
  assign age_o   = lag_w;

endmodule

// File: rtl/ltt_match.sv
module ltt_match #(
  parameter int N      = 8,
  parameter int ADDR_W = 32
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N*ADDR_W-1:0] addr_flat_i,
  input  logic [ADDR_W-1:0]   key_i,
  output logic [N-1:0]        hit_o,
  output logic                hit_any_o,
  output logic [N-1:0]        free_o,
  output logic                full_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (addr_flat_i[g*ADDR_W +: ADDR_W] == key_i);
  end

  assign hit_any_o = |hit_o;
  assign full_o    = &valid_i;

  // Lowest-numbered free slot, one-hot.
  always_comb begin
    logic taken;
    taken  = 1'b0;
    free_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !taken) begin
        free_o[i] = 1'b1;
        taken     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ltt_pick.sv
module ltt_pick #(
  parameter int N      = 8,
  parameter int TIME_W = 16
) (
  input  logic [N-1:0]        due_i,
  input  logic [N*TIME_W-1:0] age_flat_i,
  output logic [N-1:0]        pick_o,
  output logic                any_o
);

  // Largest lag means earliest deadline; strict compare keeps the lower slot on ties.
  always_comb begin
    logic [TIME_W-1:0] best;
    logic              found;
    best   = '0;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N; i++) begin
      if (due_i[i] && (!found || age_flat_i[i*TIME_W +: TIME_W] > best)) begin
        best   = age_flat_i[i*TIME_W +: TIME_W];
        found  = 1'b1;
        pick_o = '0;
        pick_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |due_i;

endmodule

// File: rtl/line_timer_table.sv
module line_timer_table #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int TIME_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              unset_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TIME_W-2:0] timeout_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] ready_addr_o,
  output logic              set_reject_o
);
  import ltt_pkg::*;

  localparam int N      = NUM_ENTRIES;
  localparam int STEP_W = TIME_W - 1;

  function automatic logic [TIME_W-1:0] deadline_of(input logic [TIME_W-1:0] now,
                                                     input logic [STEP_W-1:0] step);
    return now + {1'b0, step};
  endfunction

  logic [TIME_W-1:0]   now_q;
  logic [N-1:0]        valid_vec;
  logic [N-1:0]        due_vec;
  logic [N*ADDR_W-1:0] addr_flat;
  logic [N*TIME_W-1:0] age_flat;
  logic [N-1:0]        hit_vec;
  logic                hit_any;
  logic [N-1:0]        free_vec;
  logic                full_w;
  logic [N-1:0]        pick_vec;
  logic                due_any;
  logic [N-1:0]        load_vec;
  logic [N-1:0]        drop_vec;
  logic [TIME_W-1:0]   new_dl;
  ltt_op_e             op_w;
  logic                arm_ok;
  logic                arm_refused;
  logic                take_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign op_w        = rank_op(set_i, unset_i, pop_i);
  assign arm_ok      = (op_w == OP_ARM) && (hit_any || !full_w);
  assign arm_refused = (op_w == OP_ARM) && !hit_any && full_w;
  assign take_ok     = (op_w == OP_TAKE) && due_any;
  assign new_dl      = deadline_of(now_q, timeout_i);

  assign load_vec = arm_ok ? (hit_any ? hit_vec : free_vec) : '0;
  assign drop_vec = ((op_w == OP_DISARM) ? hit_vec : '0) | (take_ok ? pick_vec : '0);

  for (genvar g = 0; g < N; g++) begin : g_slot
    ltt_slot #(.ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .now_i      (now_q),
      .load_i     (load_vec[g]),
      .drop_i     (drop_vec[g]),
      .addr_i     (addr_i),
      .deadline_i (new_dl),
      .valid_o    (valid_vec[g]),
      .addr_o     (addr_flat[g*ADDR_W +: ADDR_W]),
      .due_o      (due_vec[g]),
      .age_o      (age_flat[g*TIME_W +: TIME_W])
    );
  end

  ltt_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .valid_i     (valid_vec),
    .addr_flat_i (addr_flat),
    .key_i       (addr_i),
    .hit_o       (hit_vec),
    .hit_any_o   (hit_any),
    .free_o      (free_vec),
    .full_o      (full_w)
  );

  ltt_pick #(.N(N), .TIME_W(TIME_W)) u_pick (
    .due_i      (due_vec),
    .age_flat_i (age_flat),
    .pick_o     (pick_vec),
    .any_o      (due_any)
  );

  always_comb begin
    ready_addr_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pick_vec[i]) ready_addr_o = ready_addr_o | addr_flat[i*ADDR_W +: ADDR_W];
    end
  end

  assign ready_o = due_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_reject_o <= 1'b0;
    else        set_reject_o <= arm_refused;
  end

endmodule

// File: rtl/ltt_chk.sv
module ltt_chk #(
  parameter int N      = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_i,
  input logic              unset_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              set_reject_o,
  input logic [N-1:0]      valid_vec,
  input logic [N*ADDR_W-1:0] addr_flat,
  input logic [N-1:0]      hit_vec,
  input logic              full_w
);

  logic [ADDR_W-1:0] prev_addr;
  logic [N-1:0]      prev_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_addr <= '0;
    else        prev_addr <= addr_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_prev
    assign prev_hit[g] = valid_vec[g] && (addr_flat[g*ADDR_W +: ADDR_W] == prev_addr);
  end

  // R3
  no_dup_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !(full_w && hit_vec == '0)) |=> (prev_hit != '0));

  // R4
  unset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unset_i && !set_i) |=> (prev_hit == '0));

  // R5
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && full_w && hit_vec == '0) |=> (set_reject_o && $stable(valid_vec)));

  // R7
  due_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !set_i && !unset_i && !pop_i) |=> ready_o);

  // R8
  pop_removes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !set_i && !unset_i && ready_o) |=>
      (int'($countones(valid_vec)) == int'($past($countones(valid_vec))) - 1));

  // R8
  pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !set_i && !unset_i && !ready_o) |=> $stable(valid_vec));

endmodule

bind line_timer_table ltt_chk #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_ltt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_i        (set_i),
  .unset_i      (unset_i),
  .pop_i        (pop_i),
  .addr_i       (addr_i),
  .ready_o      (ready_o),
  .set_reject_o (set_reject_o),
  .valid_vec    (valid_vec),
  .addr_flat    (addr_flat),
  .hit_vec      (hit_vec),
  .full_w       (full_w)
);

// File: tb/line_timer_table_test.sv
`timescale 1ns/1ps
module line_timer_table_test;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_i = 1'b0, unset_i = 1'b0, pop_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [TW-2:0] timeout_i = '0;
  logic          ready_o, set_reject_o;
  logic [AW-1:0] ready_addr_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  line_timer_table #(.NUM_ENTRIES(N), .ADDR_W(AW), .TIME_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .unset_i(unset_i), .pop_i(pop_i),
    .addr_i(addr_i), .timeout_i(timeout_i), .ready_o(ready_o),
    .ready_addr_o(ready_addr_o), .set_reject_o(set_reject_o)
  );

  // Reference table with an unbounded clock.
  bit          mv[N];
  logic [AW-1:0] ma[N];
  int          md[N];
  int          now_m = 0;
  bit          rej_m = 0;

  function automatic int m_pick();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (mv[i] && now_m >= md[i] && (best < 0 || md[i] < md[best])) best = i;
    return best;
  endfunction

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int p;
    p = m_pick();
    expect_eq(tag, "ready_o", int'(ready_o), int'(p >= 0));
    if (p >= 0) expect_eq(tag, "ready_addr_o", int'(ready_addr_o), int'(ma[p]));
    expect_eq(tag, "set_reject_o", int'(set_reject_o), int'(rej_m));
  endtask

  // Drive at falling edge, update reference at rising edge, compare at next falling edge.
  task automatic step(input bit s, input bit u, input bit p, input int a, input int to, input string tag);
    int pk, hit, fr;
    set_i = s; unset_i = u; pop_i = p; addr_i = AW'(a); timeout_i = (TW-1)'(to);
    @(posedge clk);
    pk = m_pick(); hit = -1; fr = -1; rej_m = 0;
    for (int i = 0; i < N; i++) begin
      if (mv[i] && ma[i] == AW'(a)) hit = i;
      if (!mv[i] && fr < 0) fr = i;
    end
    if (s) begin
      if (hit >= 0)    md[hit] = now_m + to;
      else if (fr >= 0) begin mv[fr] = 1; ma[fr] = AW'(a); md[fr] = now_m + to; end
      else rej_m = 1;
    end else if (u) begin
      if (hit >= 0) mv[hit] = 0;
    end else if (p) begin
      if (pk >= 0) mv[pk] = 0;
    end
    now_m++;
    @(negedge clk);
    set_i = 0; unset_i = 0; pop_i = 0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 40; k++) begin
      if (m_pick() < 0) break;
      step(0, 0, 1, 0, 0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = '0; md[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_eq("R1", "ready_o in reset", int'(ready_o), 0);
    expect_eq("R1", "set_reject_o in reset", int'(set_reject_o), 0);
    rst_n = 1'b1;
    compare("R1");

    // R2: timeouts 0, 1 and 5, exact due edge
    step(1, 0, 0, 8'h10, 0, "R2"); drain("R2");
    step(1, 0, 0, 8'h11, 1, "R2"); drain("R2");
    step(1, 0, 0, 8'h12, 5, "R2"); idle(6, "R2"); drain("R2");

    // R3: re-arm moves the deadline, keeps one slot
    step(1, 0, 0, 8'h20, 4, "R3"); idle(2, "R3");
    step(1, 0, 0, 8'h20, 9, "R3"); idle(10, "R3"); drain("R3");

    // R4: unset present and absent addresses
    step(1, 0, 0, 8'h30, 6, "R4");
    step(0, 1, 0, 8'h31, 0, "R4");
    idle(7, "R4");
    step(1, 0, 0, 8'h32, 3, "R4");
    step(0, 1, 0, 8'h32, 0, "R4"); idle(5, "R4"); drain("R4");

    // R5: full table refuses new address, accepts re-arm
    for (int i = 0; i < N; i++) step(1, 0, 0, 8'h40 + i, 20 + i, "R5");
    step(1, 0, 0, 8'h4F, 2, "R5");
    step(1, 0, 0, 8'h42, 2, "R5");
    idle(3, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(1, 0, 0, 8'h4F, 2, "R5");
    idle(22, "R5"); drain("R5");

    // R6: earliest deadline first, tie goes to lower slot
    step(1, 0, 0, 8'h51, 6, "R6");
    step(1, 0, 0, 8'h52, 5, "R6");
    step(1, 0, 0, 8'h53, 2, "R6");
    idle(8, "R6"); drain("R6");

    // R7: independent timers, due entry stays reported
    step(1, 0, 0, 8'h61, 3, "R7");
    step(1, 0, 0, 8'h62, 12, "R7");
    idle(6, "R7");
    step(0, 1, 0, 8'h62, 0, "R7");
    idle(4, "R7"); drain("R7");

    // R8: pop with nothing due
    step(1, 0, 0, 8'h70, 8, "R8");
    step(0, 0, 1, 0, 0, "R8");
    idle(8, "R8");
    step(0, 0, 1, 0, 0, "R8");
    step(0, 0, 1, 0, 0, "R8");

    // R9: command ranking
    step(1, 0, 0, 8'h80, 0, "R9");
    step(1, 0, 1, 8'h81, 9, "R9");
    step(0, 1, 1, 8'h81, 0, "R9");
    step(1, 1, 0, 8'h82, 1, "R9");
    drain("R9");

    // R10: long randomized run across many counter wraps
    for (int c = 0; c < 1500; c++) begin
      bit s, u, p, force_pop;
      int r, a, to;
      force_pop = 0;
      for (int i = 0; i < N; i++) if (mv[i] && now_m - md[i] > 12) force_pop = 1;
      r  = int'($urandom_range(0, 99));
      a  = 8'h90 + int'($urandom_range(0, 5));
      to = int'($urandom_range(0, 31));
      s = (r < 30); u = (r >= 30 && r < 40); p = (r >= 40 && r < 75);
      if (force_pop) begin s = 0; u = 0; p = 1; end
      step(s, u, p, a, to, "R10");
    end
    drain("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule